// File: doc/BRIEF.md
# Bus Clock Enable Tree

This block takes one fast system clock and produces a family of single-cycle clock-enable strobes for a microcontroller-style bus hierarchy. Every output is a qualifier sampled on the system clock, not a clock of its own. The outputs are a core/main-bus enable, two peripheral-bus enables, a timer enable for each peripheral bus, an ADC enable, a USB enable, a core tick enable and an external-memory enable. The system clock is taken to run at the PLL rate, so the USB path divides the system clock directly.

Divider codes come in on plain configuration inputs that software-visible registers elsewhere would drive. Each divider holds an active copy of its code and loads a new value only in the cycle where its own counter reaches its terminal count. A change therefore never cuts short or lengthens the period that is already running. A status output reports when the first peripheral bus would run at the full system rate, which is above its permitted limit.

Top module: `clk_en_tree`

## Requirements
- R1: Main-bus code (`cfg_ahb`) 0..8 selects division of the system clock by 1, 2, 4, 8, 16, 64, 128, 256 or 512. Codes 9..15 divide by 1.
- R2: Each peripheral-bus code (`cfg_apb1`, `cfg_apb2`) 0..4 selects division of the main-bus enable by 1, 2, 4, 8 or 16. Codes 5..7 divide by 1. A peripheral-bus pulse always coincides with a main-bus pulse.
- R3: A peripheral timer enable equals its bus enable when that bus divides by 1. Otherwise it pulses at twice the bus enable rate, and every bus pulse is also a timer pulse.
- R4: ADC code (`cfg_adc`) 0, 1, 2, 3 divides the second peripheral-bus enable by 2, 4, 6 or 8.
- R5: With `cfg_usb_frac` = 0 the USB enable is high every cycle. With 1 it is high on exactly 2 of every 3 cycles and is never low in two consecutive cycles.
- R6: `apb1_overspeed` is high exactly when the active main-bus ratio and the active first peripheral-bus ratio are both 1. While it is high, the first peripheral-bus enable is high every cycle.
- R7: The core tick enable pulses once per 8 main-bus pulses.
- R8: The external-memory enable pulses once per 2 main-bus pulses.
- R9: A new divider code takes effect only at the divider's own terminal count. After a peripheral-bus code changes mid-period, the running interval completes at the old ratio and the next interval uses the new ratio.
- R10: After reset, with all codes 0, the main-bus, both peripheral-bus, both timer and USB enables are high in every cycle, and `apb1_overspeed` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (PLL rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ahb | input | 4 | Main-bus divider code |
| cfg_apb1 | input | 3 | First peripheral-bus divider code |
| cfg_apb2 | input | 3 | Second peripheral-bus divider code |
| cfg_adc | input | 2 | ADC divider code |
| cfg_usb_frac | input | 1 | 1 selects USB divide by 1.5, 0 divide by 1 |
| hclk_en | output | 1 | Main-bus enable |
| pclk1_en | output | 1 | First peripheral-bus enable |
| pclk2_en | output | 1 | Second peripheral-bus enable |
| tim1_en | output | 1 | Timer enable for the first peripheral bus |
| tim2_en | output | 1 | Timer enable for the second peripheral bus |
| adc_en | output | 1 | ADC enable |
| usb_en | output | 1 | USB enable |
| systick_en | output | 1 | Core tick enable |
| extmem_en | output | 1 | External-memory interface enable |
| apb1_overspeed | output | 1 | First peripheral bus configured above its rate limit |

## Verification
The properties assume only that reset is held low and then released, and that configuration codes are held steady around the rising clock edge. They place no limit on which codes appear or on when they change, because the nesting of enables and the minimum gaps hold for any code, including reserved ones. The stimulus changes codes only on the falling edge, uses reserved values on both bus dividers, and waits after each change for every affected divider to reach its terminal count before it measures pulse counts over a window that is a whole multiple of every period.

// File: rtl/clk_en_tree.sv
module clk_en_tree #(
  parameter int AHB_CW    = 4,
  parameter int APB_CW    = 3,
  parameter int ADC_CW    = 2,
  parameter int AHB_CNT_W = 9,
  parameter int APB_CNT_W = 4,
  parameter int TICK_DIV  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AHB_CW-1:0] cfg_ahb,
  input  logic [APB_CW-1:0] cfg_apb1,
  input  logic [APB_CW-1:0] cfg_apb2,
  input  logic [ADC_CW-1:0] cfg_adc,
  input  logic              cfg_usb_frac,
  output logic              hclk_en,
  output logic              pclk1_en,
  output logic              pclk2_en,
  output logic              tim1_en,
  output logic              tim2_en,
  output logic              adc_en,
  output logic              usb_en,
  output logic              systick_en,
  output logic              extmem_en,
  output logic              apb1_overspeed
);
  localparam int ADC_CNT_W = ADC_CW + 1;
  localparam int TICK_W    = $clog2(TICK_DIV);

  function automatic logic [AHB_CNT_W-1:0] ahb_term(input logic [AHB_CW-1:0] c);
    case (int'(c))
      1: return AHB_CNT_W'(1);
      2: return AHB_CNT_W'(3);
      3: return AHB_CNT_W'(7);
      4: return AHB_CNT_W'(15);
      5: return AHB_CNT_W'(63);
      6: return AHB_CNT_W'(127);
      7: return AHB_CNT_W'(255);
      8: return AHB_CNT_W'(511);
      default: return '0;
    endcase
  endfunction

  function automatic logic [APB_CNT_W-1:0] apb_term(input logic [APB_CW-1:0] c);
    case (int'(c))
      1: return APB_CNT_W'(1);
      2: return APB_CNT_W'(3);
      3: return APB_CNT_W'(7);
      4: return APB_CNT_W'(15);
      default: return '0;
    endcase
  endfunction

  logic [AHB_CW-1:0]    ahb_sel;
  logic [AHB_CNT_W-1:0] ahb_cnt;
  logic                 ahb_last;

  assign ahb_last = ahb_cnt == ahb_term(ahb_sel);
  assign hclk_en  = ahb_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ahb_cnt <= '0;
      ahb_sel <= '0;
    end else if (ahb_last) begin
      ahb_cnt <= '0;
      ahb_sel <= cfg_ahb;
    end else begin
      ahb_cnt <= ahb_cnt + 1'b1;
    end

  logic [1:0][APB_CW-1:0] apb_cfg;
  logic [1:0]             bus_en, tmr_en, bus_unity;

  assign apb_cfg = {cfg_apb2, cfg_apb1};

  for (genvar g = 0; g < 2; g++) begin : g_apb
    logic [APB_CW-1:0]    sel;
    logic [APB_CNT_W-1:0] cnt, term;
    logic                 last;

    assign term         = apb_term(sel);
    assign last         = cnt == term;
    assign bus_en[g]    = hclk_en & last;
    assign tmr_en[g]    = hclk_en & (last | (cnt == (term >> 1)));
    assign bus_unity[g] = term == '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        sel <= '0;
      end else if (hclk_en) begin
        if (last) begin
          cnt <= '0;
          sel <= apb_cfg[g];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
  end

  assign pclk1_en = bus_en[0];
  assign pclk2_en = bus_en[1];
  assign tim1_en  = tmr_en[0];
  assign tim2_en  = tmr_en[1];

  logic [ADC_CW-1:0]    adc_sel;
  logic [ADC_CNT_W-1:0] adc_cnt;
  logic                 adc_last;

  assign adc_last = adc_cnt == {adc_sel, 1'b1};
  assign adc_en   = pclk2_en & adc_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      adc_cnt <= '0;
      adc_sel <= '0;
    end else if (pclk2_en) begin
      if (adc_last) begin
        adc_cnt <= '0;
        adc_sel <= cfg_adc;
      end else begin
        adc_cnt <= adc_cnt + 1'b1;
      end
    end

  logic [TICK_W-1:0] tick_cnt;
  logic              ext_tgl;

  assign systick_en = hclk_en & (tick_cnt == TICK_W'(TICK_DIV - 1));
  assign extmem_en  = hclk_en & ext_tgl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tick_cnt <= '0;
      ext_tgl  <= 1'b0;
    end else if (hclk_en) begin
      tick_cnt <= tick_cnt + 1'b1;
      ext_tgl  <= ~ext_tgl;
    end

  logic [1:0] usb_cnt;
  logic       usb_sel;

  assign usb_en = ~(usb_sel & (usb_cnt == 2'd2));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      usb_cnt <= '0;
      usb_sel <= 1'b0;
    end else if (usb_cnt == 2'd2) begin
      usb_cnt <= '0;
      usb_sel <= cfg_usb_frac;
    end else begin
      usb_cnt <= usb_cnt + 1'b1;
    end

  assign apb1_overspeed = (ahb_term(ahb_sel) == '0) & bus_unity[0];
endmodule

// File: rtl/clk_en_tree_chk.sv
module clk_en_tree_chk (
  input logic clk,
  input logic rst_n,
  input logic hclk_en,
  input logic pclk1_en,
  input logic pclk2_en,
  input logic tim1_en,
  input logic tim2_en,
  input logic adc_en,
  input logic usb_en,
  input logic systick_en,
  input logic extmem_en,
  input logic apb1_overspeed
);
  // R2
  bus1_in_hclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk1_en |-> hclk_en);
  // R2
  bus2_in_hclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk2_en |-> hclk_en);
  // R3
  tim1_covers_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk1_en |-> tim1_en);
  // R3
  tim2_covers_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk2_en |-> tim2_en);
  // R4
  adc_in_bus2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> pclk2_en);
  // R4
  adc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |=> !adc_en);
  // R5
  usb_no_double_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !usb_en |=> usb_en);
  // R6
  overspeed_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apb1_overspeed |-> pclk1_en);
  // R7
  tick_in_hclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    systick_en |-> hclk_en);
  // R8
  ext_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    extmem_en |=> !extmem_en);
endmodule

bind clk_en_tree clk_en_tree_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hclk_en(hclk_en), .pclk1_en(pclk1_en),
  .pclk2_en(pclk2_en), .tim1_en(tim1_en), .tim2_en(tim2_en), .adc_en(adc_en),
  .usb_en(usb_en), .systick_en(systick_en), .extmem_en(extmem_en),
  .apb1_overspeed(apb1_overspeed)
);

// File: tb/test_clk_en_tree.sv
module test_clk_en_tree;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_ahb = '0;
  logic [2:0] cfg_apb1 = '0, cfg_apb2 = '0;
  logic [1:0] cfg_adc = '0;
  logic       cfg_usb_frac = 1'b0;
  logic hclk_en, pclk1_en, pclk2_en, tim1_en, tim2_en, adc_en, usb_en;
  logic systick_en, extmem_en, apb1_overspeed;

  always #4 clk = ~clk;

  clk_en_tree i_clk_en_tree (
    .clk(clk), .rst_n(rst_n), .cfg_ahb(cfg_ahb), .cfg_apb1(cfg_apb1),
    .cfg_apb2(cfg_apb2), .cfg_adc(cfg_adc), .cfg_usb_frac(cfg_usb_frac),
    .hclk_en(hclk_en), .pclk1_en(pclk1_en), .pclk2_en(pclk2_en),
    .tim1_en(tim1_en), .tim2_en(tim2_en), .adc_en(adc_en), .usb_en(usb_en),
    .systick_en(systick_en), .extmem_en(extmem_en),
    .apb1_overspeed(apb1_overspeed)
  );

  typedef struct { int w; int e[9]; int flag; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  int cur_a = 1, cur_p1 = 1, cur_p2 = 1;
  string nm[9]  = '{"hclk_en", "pclk1_en", "pclk2_en", "tim1_en", "tim2_en",
                    "adc_en", "usb_en", "systick_en", "extmem_en"};
  string tag[9] = '{"R1", "R2", "R2", "R3", "R3", "R4", "R5", "R7", "R8"};

  function automatic int ahb_div(int c);
    case (c)
      0: return 1;   1: return 2;   2: return 4;   3: return 8;   4: return 16;
      5: return 64;  6: return 128; 7: return 256; 8: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int apb_div(int c);
    return (c <= 4) ? (1 << c) : 1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic apply(int ca, int c1, int c2, int cd, int cu);
    int a, p1, p2, n, npow, m, w, amax, p1m, p2m;
    exp_t it;
    a = ahb_div(ca); p1 = apb_div(c1); p2 = apb_div(c2); n = 2 * (cd + 1);
    cfg_ahb = 4'(ca); cfg_apb1 = 3'(c1); cfg_apb2 = 3'(c2);
    cfg_adc = 2'(cd); cfg_usb_frac = 1'(cu);
    amax = (a > cur_a) ? a : cur_a;
    p1m  = (p1 > cur_p1) ? p1 : cur_p1;
    p2m  = (p2 > cur_p2) ? p2 : cur_p2;
    repeat (2 * amax * (p1m + 8 * p2m + 8) + 16) @(negedge clk);
    cur_a = a; cur_p1 = p1; cur_p2 = p2;
    npow = (n == 6) ? 2 : n;
    m = 8;
    if (p1 > m) m = p1;
    if (p2 * npow > m) m = p2 * npow;
    w = 3 * a * m;
    it.w    = w;
    it.e[0] = w / a;
    it.e[1] = w / (a * p1);
    it.e[2] = w / (a * p2);
    it.e[3] = w / (a * ((p1 > 1) ? p1 / 2 : 1));
    it.e[4] = w / (a * ((p2 > 1) ? p2 / 2 : 1));
    it.e[5] = w / (a * p2 * n);
    it.e[6] = cu ? (2 * w / 3) : w;
    it.e[7] = w / (8 * a);
    it.e[8] = w / (2 * a);
    it.flag = (a == 1 && p1 == 1) ? 1 : 0;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  initial begin : monitor
    exp_t it;
    int c[9];
    forever begin
      wait (q.size() > 0);
      it = q[0];
      foreach (c[i]) c[i] = 0;
      repeat (it.w) begin
        @(negedge clk);
        c[0] += int'(hclk_en);  c[1] += int'(pclk1_en); c[2] += int'(pclk2_en);
        c[3] += int'(tim1_en);  c[4] += int'(tim2_en);  c[5] += int'(adc_en);
        c[6] += int'(usb_en);   c[7] += int'(systick_en); c[8] += int'(extmem_en);
      end
      foreach (c[i]) chk(tag[i], nm[i], c[i], it.e[i]);
      chk("R6", "apb1_overspeed", int'(apb1_overspeed), it.flag);
      void'(q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    wrap_up();
  end

  initial begin : driver
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: every ratio-1 enable high in each cycle after reset
    repeat (4) begin
      @(negedge clk);
      chk("R10", "hclk_en", int'(hclk_en), 1);
      chk("R10", "pclk1_en", int'(pclk1_en), 1);
      chk("R10", "pclk2_en", int'(pclk2_en), 1);
      chk("R10", "tim1_en", int'(tim1_en), 1);
      chk("R10", "tim2_en", int'(tim2_en), 1);
      chk("R10", "usb_en", int'(usb_en), 1);
      chk("R10", "apb1_overspeed", int'(apb1_overspeed), 1);
    end
    // R1 sweep including reserved codes
    for (int ca = 1; ca <= 9; ca++) apply(ca, 0, 0, 0, 0);
    apply(15, 0, 0, 0, 1);
    // R2, R3, R6 on the first bus
    for (int c1 = 0; c1 <= 4; c1++) apply(1, c1, 0, 0, 0);
    apply(0, 6, 0, 0, 0);
    apply(0, 2, 0, 0, 0);
    // R2, R3 on the second bus
    for (int c2 = 1; c2 <= 4; c2++) apply(0, 0, c2, 0, 1);
    apply(0, 0, 7, 0, 0);
    // R4
    for (int cd = 0; cd <= 3; cd++) apply(0, 0, 2, cd, cd & 1);
    // R5 mixed
    apply(2, 3, 1, 2, 1);
    apply(3, 1, 4, 3, 1);
    apply(0, 4, 0, 0, 0);
    // R9: change the first bus code three cycles into a 16-cycle period
    k = 0;
    do @(negedge clk); while (!pclk1_en);
    do begin
      @(negedge clk);
      k++;
      if (k == 3) cfg_apb1 = 3'd1;
    end while (!pclk1_en);
    chk("R9", "interval after change", k, 16);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!pclk1_en);
    chk("R9", "interval with new code", k, 2);
    wrap_up();
  end
endmodule